// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the finite-state controller of a 16-bit multicycle processor. Every instruction walks through a check for a pending interrupt, an instruction fetch, an operand read from the register file, and then one to three execute, memory or writeback steps chosen by the 4-bit opcode. In each step the controller raises the load strobes of the datapath registers (instruction, program counter, exception program counter and the three operand temporaries). It also raises the write enables of the general registers, the special registers and memory, and drives the multiplexer selects that pick what each of them takes in.

The datapath feeds back three conditions: operand A equals operand B, operand B is less than operand C as signed values, and an interrupt request. The controller keeps its own interrupt-enable flag. The flag is cleared on interrupt entry and set by the return-from-exception opcode. All outputs are registered, so a strobe is high in exactly the cycle in which its step is active.

Top module: `mc_sequencer`

## Requirements
- R1: Synchronous reset sends the controller to the interrupt-check step with every strobe low, every select at 0 and `irq_en` low. The check step itself asserts nothing.
- R2: If `irq_pending` and `irq_en` are both high in the check step, an entry step follows. It asserts `epc_ld`, `pc_ld` with `pc_sel`=4 (general register 5) and `sreg_we` with `sr_sel`=2 (interrupt flag). It also drops `irq_en` and then goes on to fetch. A pending request while `irq_en` is low goes straight to fetch.
- R3: The fetch step asserts `ir_ld` with `ma_sel`=0 (address from PC) and `pc_ld` with `pc_sel`=0 (PC plus 4). It also asserts `sreg_we` with `sr_sel`=1, which copies the exception PC into its special register.
- R4: The decode step asserts `a_ld`, `b_ld` and `c_ld` with `a_sel`=`b_sel`=`c_sel`=0 (register file). It also asserts `sreg_we` with `sr_sel`=0, which copies PC into its special register.
- R5: Opcode 0 (A equal to B) and opcode 1 (A differs from B) spend one step testing `a_eq_b`. When the test holds, a step with `pc_ld` and `pc_sel`=1 (from C) follows. Otherwise the controller returns to the check step.
- R6: Opcodes 2, 5, 10 and 14 load A with `a_sel` 1, 2, 3 and 4 respectively (negate B, shift B, B plus C, B or C). The next step asserts `reg_we` with `wd_sel`=0 (from A).
- R7: Opcode 3 loads B with `b_sel`=1 (immediate in the high byte) and opcode 4 with `b_sel`=2 (immediate in the low byte). The next step loads B with `b_sel` 3 or 4 respectively, which merges in the other byte of A. A third step asserts `reg_we` with `wd_sel`=1 (from B).
- R8: Opcode 8 asserts `reg_we` with `wd_sel`=2 (zero). If `b_lt_c` is high, a second step asserts `reg_we` with `wd_sel`=3 (one). Otherwise the controller returns to the check step.
- R9: Opcode 9 asserts `epc_ld` and then `pc_ld` with `pc_sel`=3 (PC-relative). Opcode 11 asserts `pc_ld` with `pc_sel`=2 (from the exception PC) and raises `irq_en` in that same step.
- R10: Opcodes 12 and 13 load C with `c_sel`=1 (B plus offset). Opcode 12 then loads A with `a_sel`=5 and `ma_sel`=1, and then asserts `reg_we` with `wd_sel`=0. Opcode 13 then asserts `mem_we` with `ma_sel`=1. `mem_we` and `reg_we` are never high together.
- R11: Opcode 15 spends one step idle. If `asp_dir` is 1, it then asserts `sreg_we` with `sr_sel`=3 (special register named in the instruction). If `asp_dir` is 0, it asserts `reg_we` with `wd_sel`=4 (from the special register).
- R12: Opcodes 6 and 7 go from decode straight back to the check step with no strobe in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | OP_W | Opcode field of the held instruction |
| asp_dir | input | 1 | Direction bit of the special-register move |
| irq_pending | input | 1 | Interrupt request |
| a_eq_b | input | 1 | Comparator result, A equals B |
| b_lt_c | input | 1 | Signed B less than C |
| ir_ld | output | 1 | Instruction register load |
| pc_ld | output | 1 | Program counter load |
| epc_ld | output | 1 | Exception PC load (takes PC) |
| a_ld | output | 1 | Temporary A load |
| b_ld | output | 1 | Temporary B load |
| c_ld | output | 1 | Temporary C load |
| reg_we | output | 1 | General register write (destination field) |
| sreg_we | output | 1 | Special register write |
| mem_we | output | 1 | Memory write of A |
| pc_sel | output | 3 | 0 PC+4, 1 C, 2 EPC, 3 relative, 4 register 5 |
| a_sel | output | 3 | 0 register, 1 negate, 2 shift, 3 add, 4 or, 5 memory |
| b_sel | output | 3 | 0 register, 1 imm high, 2 imm low, 3 merge high, 4 merge low |
| c_sel | output | 1 | 0 register, 1 address sum |
| wd_sel | output | 3 | 0 A, 1 B, 2 zero, 3 one, 4 special register |
| sr_sel | output | 2 | 0 PC slot, 1 EPC slot, 2 flag slot, 3 instruction field |
| ma_sel | output | 1 | Memory address 0 PC, 1 C |
| irq_en | output | 1 | Interrupt-enable flag |

## Verification
The hardest case to reach is interrupt entry. It needs the enable flag set, which only a completed opcode 11 does, and a request that is present in the single check cycle that follows. Entry also clears the flag again. The stimulus therefore issues opcode 11 directly before a request and also lets random streams mix opcode 11 in. The bench tracks the flag in its own model, so each request is predicted as taken or ignored. The data-dependent exits of opcodes 0, 1 and 8 are driven with both values of their condition.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    ST_CHECK, ST_IRQ, ST_FETCH, ST_DECODE, ST_EX1, ST_EX2, ST_EX3
  } state_e;

  typedef struct packed {
    logic       ir_ld;
    logic       pc_ld;
    logic       epc_ld;
    logic       a_ld;
    logic       b_ld;
    logic       c_ld;
    logic       reg_we;
    logic       sreg_we;
    logic       mem_we;
    logic [2:0] pc_sel;
    logic [2:0] a_sel;
    logic [2:0] b_sel;
    logic       c_sel;
    logic [2:0] wd_sel;
    logic [1:0] sr_sel;
    logic       ma_sel;
  } ctl_t;

  localparam logic [2:0] PCS_INC = 3'd0, PCS_C = 3'd1, PCS_EPC = 3'd2,
                         PCS_REL = 3'd3, PCS_R5 = 3'd4;
  localparam logic [2:0] AS_REG = 3'd0, AS_NEG = 3'd1, AS_SHIFT = 3'd2,
                         AS_ADD = 3'd3, AS_OR = 3'd4, AS_MEM = 3'd5;
  localparam logic [2:0] BS_REG = 3'd0, BS_IMM_HI = 3'd1, BS_IMM_LO = 3'd2,
                         BS_MRG_HI = 3'd3, BS_MRG_LO = 3'd4;
  localparam logic       CS_REG = 1'b0, CS_ADDR = 1'b1;
  localparam logic [2:0] WD_A = 3'd0, WD_B = 3'd1, WD_ZERO = 3'd2,
                         WD_ONE = 3'd3, WD_SREG = 3'd4;
  localparam logic [1:0] SR_PC = 2'd0, SR_EPC = 2'd1, SR_FLAG = 2'd2,
                         SR_FIELD = 2'd3;
  localparam logic       MA_PC = 1'b0, MA_C = 1'b1;

  localparam ctl_t CTL_IDLE = '0;

endpackage

// File: rtl/mcs_next.sv
module mcs_next
  import mcs_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  state_e          state_q,
  input  logic [OP_W-1:0] op_code,
  input  logic            irq_take,
  input  logic            a_eq_b,
  input  logic            b_lt_c,
  output state_e          state_d
);
  always_comb begin
    state_d = ST_CHECK;
    case (state_q)
      ST_CHECK:  state_d = irq_take ? ST_IRQ : ST_FETCH;
      ST_IRQ:    state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = (op_code == OP_W'(6) || op_code == OP_W'(7))
                           ? ST_CHECK : ST_EX1;
      ST_EX1: begin
        if (op_code == OP_W'(0))       state_d = a_eq_b  ? ST_EX2 : ST_CHECK;
        else if (op_code == OP_W'(1))  state_d = !a_eq_b ? ST_EX2 : ST_CHECK;
        else if (op_code == OP_W'(8))  state_d = b_lt_c  ? ST_EX2 : ST_CHECK;
        else if (op_code == OP_W'(11)) state_d = ST_CHECK;
        else                           state_d = ST_EX2;
      end
      ST_EX2: state_d = (op_code == OP_W'(3) || op_code == OP_W'(4) ||
                         op_code == OP_W'(12)) ? ST_EX3 : ST_CHECK;
      default: state_d = ST_CHECK;
    endcase
  end
endmodule

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  state_e          state,
  input  logic [OP_W-1:0] op_code,
  input  logic            asp_dir,
  output ctl_t            ctl
);
  always_comb begin
    ctl = CTL_IDLE;
    case (state)
      ST_IRQ: begin
        ctl.epc_ld  = 1'b1;
        ctl.pc_ld   = 1'b1;
        ctl.pc_sel  = PCS_R5;
        ctl.sreg_we = 1'b1;
        ctl.sr_sel  = SR_FLAG;
      end
      ST_FETCH: begin
        ctl.ir_ld   = 1'b1;
        ctl.ma_sel  = MA_PC;
        ctl.pc_ld   = 1'b1;
        ctl.pc_sel  = PCS_INC;
        ctl.sreg_we = 1'b1;
        ctl.sr_sel  = SR_EPC;
      end
      ST_DECODE: begin
        ctl.a_ld    = 1'b1;
        ctl.b_ld    = 1'b1;
        ctl.c_ld    = 1'b1;
        ctl.sreg_we = 1'b1;
        ctl.sr_sel  = SR_PC;
      end
      ST_EX1: begin
        case (op_code)
          OP_W'(2):  begin ctl.a_ld = 1'b1; ctl.a_sel = AS_NEG;   end
          OP_W'(5):  begin ctl.a_ld = 1'b1; ctl.a_sel = AS_SHIFT; end
          OP_W'(10): begin ctl.a_ld = 1'b1; ctl.a_sel = AS_ADD;   end
          OP_W'(14): begin ctl.a_ld = 1'b1; ctl.a_sel = AS_OR;    end
          OP_W'(3):  begin ctl.b_ld = 1'b1; ctl.b_sel = BS_IMM_HI; end
          OP_W'(4):  begin ctl.b_ld = 1'b1; ctl.b_sel = BS_IMM_LO; end
          OP_W'(8):  begin ctl.reg_we = 1'b1; ctl.wd_sel = WD_ZERO; end
          OP_W'(9):  ctl.epc_ld = 1'b1;
          OP_W'(11): begin ctl.pc_ld = 1'b1; ctl.pc_sel = PCS_EPC; end
          OP_W'(12), OP_W'(13): begin ctl.c_ld = 1'b1; ctl.c_sel = CS_ADDR; end
          default: ctl = CTL_IDLE;
        endcase
      end
      ST_EX2: begin
        case (op_code)
          OP_W'(0), OP_W'(1): begin ctl.pc_ld = 1'b1; ctl.pc_sel = PCS_C; end
          OP_W'(2), OP_W'(5), OP_W'(10), OP_W'(14): begin
            ctl.reg_we = 1'b1;
            ctl.wd_sel = WD_A;
          end
          OP_W'(3):  begin ctl.b_ld = 1'b1; ctl.b_sel = BS_MRG_HI; end
          OP_W'(4):  begin ctl.b_ld = 1'b1; ctl.b_sel = BS_MRG_LO; end
          OP_W'(8):  begin ctl.reg_we = 1'b1; ctl.wd_sel = WD_ONE; end
          OP_W'(9):  begin ctl.pc_ld = 1'b1; ctl.pc_sel = PCS_REL; end
          OP_W'(12): begin
            ctl.a_ld   = 1'b1;
            ctl.a_sel  = AS_MEM;
            ctl.ma_sel = MA_C;
          end
          OP_W'(13): begin ctl.mem_we = 1'b1; ctl.ma_sel = MA_C; end
          OP_W'(15): begin
            if (asp_dir) begin
              ctl.sreg_we = 1'b1;
              ctl.sr_sel  = SR_FIELD;
            end else begin
              ctl.reg_we = 1'b1;
              ctl.wd_sel = WD_SREG;
            end
          end
          default: ctl = CTL_IDLE;
        endcase
      end
      ST_EX3: begin
        ctl.reg_we = 1'b1;
        ctl.wd_sel = (op_code == OP_W'(12)) ? WD_A : WD_B;
      end
      default: ctl = CTL_IDLE;
    endcase
  end
endmodule

// File: rtl/mcs_ien.sv
module mcs_ien
  import mcs_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  state_e          state_d,
  input  logic [OP_W-1:0] op_code,
  output logic            ien_q
);
  always_ff @(posedge clk) begin
    if (rst)
      ien_q <= 1'b0;
    else if (state_d == ST_IRQ)
      ien_q <= 1'b0;
    else if (state_d == ST_EX1 && op_code == OP_W'(11))
      ien_q <= 1'b1;
  end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mcs_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_code,
  input  logic            asp_dir,
  input  logic            irq_pending,
  input  logic            a_eq_b,
  input  logic            b_lt_c,
  output logic            ir_ld,
  output logic            pc_ld,
  output logic            epc_ld,
  output logic            a_ld,
  output logic            b_ld,
  output logic            c_ld,
  output logic            reg_we,
  output logic            sreg_we,
  output logic            mem_we,
  output logic [2:0]      pc_sel,
  output logic [2:0]      a_sel,
  output logic [2:0]      b_sel,
  output logic            c_sel,
  output logic [2:0]      wd_sel,
  output logic [1:0]      sr_sel,
  output logic            ma_sel,
  output logic            irq_en
);
  state_e state_q, state_d;
  ctl_t   ctl_d, ctl_q;
  logic   ien_q;

  mcs_next #(.OP_W(OP_W)) u_next (
    .state_q  (state_q),
    .op_code  (op_code),
    .irq_take (irq_pending && ien_q),
    .a_eq_b   (a_eq_b),
    .b_lt_c   (b_lt_c),
    .state_d  (state_d)
  );

  mcs_decode #(.OP_W(OP_W)) u_decode (
    .state   (state_d),
    .op_code (op_code),
    .asp_dir (asp_dir),
    .ctl     (ctl_d)
  );

  mcs_ien #(.OP_W(OP_W)) u_ien (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .op_code (op_code),
    .ien_q   (ien_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CHECK;
      ctl_q   <= CTL_IDLE;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  assign ir_ld   = ctl_q.ir_ld;
  assign pc_ld   = ctl_q.pc_ld;
  assign epc_ld  = ctl_q.epc_ld;
  assign a_ld    = ctl_q.a_ld;
  assign b_ld    = ctl_q.b_ld;
  assign c_ld    = ctl_q.c_ld;
  assign reg_we  = ctl_q.reg_we;
  assign sreg_we = ctl_q.sreg_we;
  assign mem_we  = ctl_q.mem_we;
  assign pc_sel  = ctl_q.pc_sel;
  assign a_sel   = ctl_q.a_sel;
  assign b_sel   = ctl_q.b_sel;
  assign c_sel   = ctl_q.c_sel;
  assign wd_sel  = ctl_q.wd_sel;
  assign sr_sel  = ctl_q.sr_sel;
  assign ma_sel  = ctl_q.ma_sel;
  assign irq_en  = ien_q;
endmodule

// File: rtl/mc_sequencer_chk.sv
module mc_sequencer_chk #(
  parameter int OP_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op_code,
  input logic            asp_dir,
  input logic            irq_pending,
  input logic            a_eq_b,
  input logic            b_lt_c,
  input logic            ir_ld,
  input logic            pc_ld,
  input logic            epc_ld,
  input logic            a_ld,
  input logic            b_ld,
  input logic            c_ld,
  input logic            reg_we,
  input logic            sreg_we,
  input logic            mem_we,
  input logic [2:0]      pc_sel,
  input logic [2:0]      a_sel,
  input logic [2:0]      b_sel,
  input logic            c_sel,
  input logic [2:0]      wd_sel,
  input logic [1:0]      sr_sel,
  input logic            ma_sel,
  input logic            irq_en
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !(ir_ld || pc_ld || epc_ld || a_ld || b_ld || c_ld ||
              reg_we || sreg_we || mem_we || irq_en));

  assert_entry_disables_R2: assert property (@(posedge clk) disable iff (rst)
    (sreg_we && sr_sel == 2'd2) |-> (!irq_en && epc_ld && pc_sel == 3'd4));

  assert_fetch_then_decode_R4: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (a_ld && b_ld && c_ld && !ir_ld));

  assert_fetch_advances_pc_R3: assert property (@(posedge clk) disable iff (rst)
    ir_ld |-> (pc_ld && pc_sel == 3'd0 && ma_sel == 1'b0));

  assert_enable_on_return_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_en) |-> (pc_ld && pc_sel == 3'd2));

  assert_no_dual_write_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && reg_we));
endmodule

bind mc_sequencer mc_sequencer_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/mc_sequencer_bench.sv
module mc_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op_code = '0;
  logic asp_dir = 1'b0, irq_pending = 1'b0, a_eq_b = 1'b0, b_lt_c = 1'b0;
  logic ir_ld, pc_ld, epc_ld, a_ld, b_ld, c_ld, reg_we, sreg_we, mem_we;
  logic [2:0] pc_sel, a_sel, b_sel, wd_sel;
  logic c_sel, ma_sel, irq_en;
  logic [1:0] sr_sel;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 1'b0;
  logic ien_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_sequencer u_mc_sequencer (.*);

  function automatic logic [25:0] mk(input logic [8:0] stb, input logic [2:0] pcs,
      input logic [2:0] as, input logic [2:0] bs, input logic cs,
      input logic [2:0] wd, input logic [1:0] sr, input logic ma, input logic en);
    return {stb, pcs, as, bs, cs, wd, sr, ma, en};
  endfunction

  function automatic logic [25:0] got();
    return {ir_ld, pc_ld, epc_ld, a_ld, b_ld, c_ld, reg_we, sreg_we, mem_we,
            pc_sel, a_sel, b_sel, c_sel, wd_sel, sr_sel, ma_sel, irq_en};
  endfunction

  task automatic cmp(input logic [25:0] exp, input string tag);
    n_cmp++;
    if (got() !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d: got %h expected %h", tag, op_code, got(), exp);
    end
  endtask

  // strobe order: ir pc epc a b c reg sreg mem
  task automatic run_instr(input logic [3:0] op, input logic dir, input logic eq,
                           input logic lt, input logic irq);
    logic [25:0] e[8];
    string tg[8];
    int n = 0;
    op_code = op; asp_dir = dir; a_eq_b = eq; b_lt_c = lt; irq_pending = irq;
    cmp(mk(9'b0, 0, 0, 0, 0, 0, 0, 0, ien_m), "R1 check step idle");
    if (irq && ien_m) begin
      ien_m = 1'b0;
      e[n] = mk(9'b011000010, 3'd4, 0, 0, 0, 0, 2'd2, 0, 1'b0); tg[n] = "R2 entry"; n++;
    end
    e[n] = mk(9'b110000010, 3'd0, 0, 0, 0, 0, 2'd1, 0, ien_m); tg[n] = "R3 fetch"; n++;
    e[n] = mk(9'b000111010, 0, 0, 0, 0, 0, 2'd0, 0, ien_m); tg[n] = "R4 decode"; n++;
    case (op)
      4'd0, 4'd1: if ((op == 4'd0) == eq) begin
        e[n] = mk(9'b0, 0, 0, 0, 0, 0, 0, 0, ien_m); tg[n] = "R5 test"; n++;
        e[n] = mk(9'b010000000, 3'd1, 0, 0, 0, 0, 0, 0, ien_m); tg[n] = "R5 taken"; n++;
      end else begin
        e[n] = mk(9'b0, 0, 0, 0, 0, 0, 0, 0, ien_m); tg[n] = "R5 not taken"; n++;
      end
      4'd2, 4'd5, 4'd10, 4'd14: begin
        e[n] = mk(9'b000100000, 0,
                  (op == 4'd2) ? 3'd1 : (op == 4'd5) ? 3'd2 : (op == 4'd10) ? 3'd3 : 3'd4,
                  0, 0, 0, 0, 0, ien_m); tg[n] = "R6 compute"; n++;
        e[n] = mk(9'b000000100, 0, 0, 0, 0, 3'd0, 0, 0, ien_m); tg[n] = "R6 write"; n++;
      end
      4'd3, 4'd4: begin
        e[n] = mk(9'b000010000, 0, 0, (op == 4'd3) ? 3'd1 : 3'd2, 0, 0, 0, 0, ien_m);
        tg[n] = "R7 immediate"; n++;
        e[n] = mk(9'b000010000, 0, 0, (op == 4'd3) ? 3'd3 : 3'd4, 0, 0, 0, 0, ien_m);
        tg[n] = "R7 merge"; n++;
        e[n] = mk(9'b000000100, 0, 0, 0, 0, 3'd1, 0, 0, ien_m); tg[n] = "R7 write"; n++;
      end
      4'd8: begin
        e[n] = mk(9'b000000100, 0, 0, 0, 0, 3'd2, 0, 0, ien_m); tg[n] = "R8 zero"; n++;
        if (lt) begin
          e[n] = mk(9'b000000100, 0, 0, 0, 0, 3'd3, 0, 0, ien_m); tg[n] = "R8 one"; n++;
        end
      end
      4'd9: begin
        e[n] = mk(9'b001000000, 0, 0, 0, 0, 0, 0, 0, ien_m); tg[n] = "R9 save"; n++;
        e[n] = mk(9'b010000000, 3'd3, 0, 0, 0, 0, 0, 0, ien_m); tg[n] = "R9 jump"; n++;
      end
      4'd11: begin
        ien_m = 1'b1;
        e[n] = mk(9'b010000000, 3'd2, 0, 0, 0, 0, 0, 0, 1'b1); tg[n] = "R9 return"; n++;
      end
      4'd12, 4'd13: begin
        e[n] = mk(9'b000001000, 0, 0, 0, 1'b1, 0, 0, 0, ien_m); tg[n] = "R10 address"; n++;
        if (op == 4'd12) begin
          e[n] = mk(9'b000100000, 0, 3'd5, 0, 0, 0, 0, 1'b1, ien_m); tg[n] = "R10 read"; n++;
          e[n] = mk(9'b000000100, 0, 0, 0, 0, 3'd0, 0, 0, ien_m); tg[n] = "R10 write"; n++;
        end else begin
          e[n] = mk(9'b000000001, 0, 0, 0, 0, 0, 0, 1'b1, ien_m); tg[n] = "R10 store"; n++;
        end
      end
      4'd15: begin
        e[n] = mk(9'b0, 0, 0, 0, 0, 0, 0, 0, ien_m); tg[n] = "R11 idle"; n++;
        if (dir) e[n] = mk(9'b000000010, 0, 0, 0, 0, 0, 2'd3, 0, ien_m);
        else     e[n] = mk(9'b000000100, 0, 0, 0, 0, 3'd4, 0, 0, ien_m);
        tg[n] = "R11 move"; n++;
      end
      default: ; // R12: opcodes 6 and 7 end after decode
    endcase
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      cmp(e[i], tg[i]);
    end
    @(posedge clk); @(negedge clk);
    if (op == 4'd6 || op == 4'd7)
      cmp(mk(9'b0, 0, 0, 0, 0, 0, 0, 0, ien_m), "R12 back to check");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    cmp(mk(9'b0, 0, 0, 0, 0, 0, 0, 0, 1'b0), "R1 in reset");
    rst = 1'b0;
    // directed corners
    run_instr(4'd10, 0, 0, 0, 1);  // R2 request ignored while disabled
    run_instr(4'd11, 0, 0, 0, 0);  // R9 enables
    run_instr(4'd2, 0, 0, 0, 1);   // R2 entry taken
    run_instr(4'd5, 0, 0, 0, 1);   // R2 ignored again after entry
    run_instr(4'd0, 0, 1, 0, 0);
    run_instr(4'd0, 0, 0, 0, 0);
    run_instr(4'd1, 0, 0, 0, 0);
    run_instr(4'd1, 0, 1, 0, 0);
    run_instr(4'd8, 0, 0, 1, 0);
    run_instr(4'd8, 0, 0, 0, 0);
    run_instr(4'd3, 0, 0, 0, 0);
    run_instr(4'd4, 0, 0, 0, 0);
    run_instr(4'd9, 0, 0, 0, 0);
    run_instr(4'd12, 0, 0, 0, 0);
    run_instr(4'd13, 0, 0, 0, 0);
    run_instr(4'd15, 1, 0, 0, 0);
    run_instr(4'd15, 0, 0, 0, 0);
    run_instr(4'd6, 0, 1, 1, 0);
    run_instr(4'd7, 1, 0, 1, 0);
    run_instr(4'd14, 0, 0, 0, 0);
    // random stream
    for (int k = 0; k < 600; k++)
      run_instr(4'($urandom % 16), 1'($urandom % 2), 1'($urandom % 2),
                1'($urandom % 2), ($urandom % 4) == 0);
    // R1: reset mid-run clears the enable flag
    run_instr(4'd11, 0, 0, 0, 0);
    rst = 1'b1; ien_m = 1'b0;
    @(posedge clk); @(negedge clk);
    cmp(mk(9'b0, 0, 0, 0, 0, 0, 0, 0, 1'b0), "R1 reset clears");
    rst = 1'b0;
    run_instr(4'd10, 0, 0, 0, 1);
    finish_run();
  end
endmodule